// File: doc/BRIEF.md
# Streaming Vector-Matrix Transform Engine

This block turns a stream of four-element signed row vectors into a stream of four-element result vectors. It does this by multiplying each vector by a 4x4 signed coefficient matrix held inside the block. One signed data input serves two purposes. After reset it carries the sixteen coefficients, one per accepted word, with `mat_ready` pacing the transfer. From then on it carries vector elements, with `vec_ready` pacing them. The block never returns to coefficient loading unless it is reset again.

Output word j of a vector is the dot product of that vector with column j of the matrix. Each product is clamped to the internal width, and so is each partial sum. The finished sum is narrowed to the output width by keeping its most significant bits. The input side follows valid/ready rules. A word is taken on a rising clock edge only when `in_valid` and the active ready are both high. The ready signals never depend on `in_valid`, so a producer may hold `in_valid` low for any number of cycles without effect. The output side has no back-pressure. `out_valid` marks every cycle that carries a result word, and the consumer must take each word in that cycle.

The `SHARED_MAC` parameter selects the datapath. With value 0 there is one multiplier per column, and the block accepts a word on every clock. With value 1 there is a single multiplier, and each accepted word occupies it for four cycles.

Top module: `vecmat_xform`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `mat_ready`, `vec_ready` and `out_valid` are low. `mat_ready` is high after the first rising edge at which `rst` is low.
- R2: In the load phase, accepted words are stored as coefficients in row-major order: word k becomes T[k/4][k%4]. After the sixteenth word, `mat_ready` drops and stays low until reset.
- R3: `mat_ready` and `vec_ready` are never high in the same cycle, and `vec_ready` stays low throughout the load phase.
- R4: In the run phase, every four accepted words form one vector A0..A3, in arrival order. Result word j equals A0*T0j + A1*T1j + A2*T2j + A3*T3j.
- R5: Each vector yields four result words, for columns 0 to 3 in that order, in four consecutive `out_valid` cycles. Vectors leave in the order they arrived.
- R6: Each product is clamped to the signed range of `INT_W` bits.
- R7: Partial sums are built in row order (row 0 first). Each addition clamps to the signed range of `INT_W` bits.
- R8: The output word is the upper `OUT_W` bits of the clamped `INT_W`-bit sum. This equals an arithmetic right shift by `INT_W-OUT_W`.
- R9: With `SHARED_MAC`=0, `vec_ready` stays high for the whole run phase, so one word is accepted per clock.
- R10: With `SHARED_MAC`=1, each accepted vector word pulls `vec_ready` low for exactly four cycles, after which it returns high.
- R11: Cycles with `in_valid` low consume nothing. Idle gaps between words leave the results unchanged.
- R12: A reset in the middle of a vector discards it and returns the block to coefficient loading. A new matrix then governs all later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | IN_W | Signed coefficient or vector element |
| in_valid | input | 1 | `in_data` holds a word to transfer |
| mat_ready | output | 1 | Block takes a coefficient word this cycle |
| vec_ready | output | 1 | Block takes a vector element this cycle |
| out_data | output | OUT_W | Signed result word |
| out_valid | output | 1 | `out_data` holds a result word this cycle |

## Verification
The bench builds two copies of the block with `IN_W`=8, `INT_W`=12 and `OUT_W`=10, one for each `SHARED_MAC` value, and drives both with the same words. With 8-bit operands, a full-scale product such as 127*127 exceeds the 12-bit internal range, so product clamping and sum clamping can both be reached with plain test vectors. The two-bit shift at the output exposes the dropped low bits. Running the two datapath variants side by side compares the one-word-per-clock pacing with the four-cycle shared pacing on identical data.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic {PH_LOAD, PH_RUN} vx_phase_e;
endpackage

// File: rtl/vx_coef_store.sv
module vx_coef_store #(
  parameter int IN_W = 14,
  parameter int DIM  = 4,
  localparam int RW  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [RW-1:0]            wr_row,
  input  logic [RW-1:0]            wr_col,
  input  logic [IN_W-1:0]          wr_data,
  input  logic [RW-1:0]            rd_row,
  output logic [DIM-1:0][IN_W-1:0] row_q
);
  logic [IN_W-1:0] mem [DIM][DIM];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row][wr_col] <= wr_data;
  end

  for (genvar c = 0; c < DIM; c++) begin : g_rd
    assign row_q[c] = mem[rd_row][c];
  end
endmodule

// File: rtl/vx_sat_mul.sv
module vx_sat_mul #(
  parameter int IN_W  = 14,
  parameter int INT_W = 16
) (
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [IN_W-1:0]  t,
  output logic signed [INT_W-1:0] p
);
  localparam int PW = 2 * IN_W;
  logic signed [PW-1:0] full;
  assign full = a * t;

  if (PW > INT_W) begin : g_clip
    logic ovf;
    assign ovf = !((&full[PW-1:INT_W-1]) || !(|full[PW-1:INT_W-1]));
    assign p = !ovf ? full[INT_W-1:0]
             : (full[PW-1] ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}});
    // R6: a clamped product keeps the sign of the exact product
    always_comb begin
      if (full != '0) begin
        p_prod_sign_r6: assert (p[INT_W-1] == full[PW-1]);
      end
    end
  end else begin : g_ext
    assign p = INT_W'(full);
  end
endmodule

// File: rtl/vx_acc_col.sv
module vx_acc_col #(
  parameter int INT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [INT_W-1:0] p,
  output logic signed [INT_W-1:0] acc
);
  logic [INT_W:0] sum;
  logic           ovf;
  assign sum = {acc[INT_W-1], acc} + {p[INT_W-1], p};
  assign ovf = sum[INT_W] ^ sum[INT_W-1];

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (en) begin
      if (first)   acc <= p;
      else if (ovf) acc <= {sum[INT_W], {(INT_W-1){~sum[INT_W]}}};
      else         acc <= sum[INT_W-1:0];
    end
  end

  // R7: adding two non-negative terms never wraps to a negative sum
  p_acc_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !first && !acc[INT_W-1] && !p[INT_W-1]) |=> !acc[INT_W-1]);
endmodule

// File: rtl/vx_seq.sv
module vx_seq
  import vx_pkg::*;
#(
  parameter int DIM        = 4,
  parameter bit SHARED_MAC = 1'b0,
  localparam int RW        = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           mat_ready,
  output logic           vec_ready,
  output logic           coef_wr,
  output logic [RW-1:0]  ld_row,
  output logic [RW-1:0]  ld_col,
  output logic [RW-1:0]  el_idx,
  output logic [DIM-1:0] col_en,
  output logic           first,
  output logic           hold_en,
  output logic           done
);
  localparam logic [RW-1:0] LAST = RW'(DIM - 1);

  vx_phase_e     phase;
  logic          busy;
  logic [RW-1:0] col;
  logic          mat_acc, vec_acc;

  assign mat_acc = mat_ready && in_valid;
  assign vec_acc = vec_ready && in_valid;
  assign coef_wr = mat_acc;
  assign hold_en = vec_acc;
  assign first   = (el_idx == '0);

  always_comb begin
    for (int c = 0; c < DIM; c++) begin
      col_en[c] = SHARED_MAC ? (busy && (col == RW'(c))) : vec_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_LOAD;
      mat_ready <= 1'b0;
      vec_ready <= 1'b0;
      busy      <= 1'b0;
      ld_row    <= '0;
      ld_col    <= '0;
      el_idx    <= '0;
      col       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_LOAD: begin
          mat_ready <= 1'b1;
          if (mat_acc) begin
            if (ld_col == LAST) begin
              ld_col <= '0;
              if (ld_row == LAST) begin
                phase     <= PH_RUN;
                mat_ready <= 1'b0;
              end else begin
                ld_row <= ld_row + 1'b1;
              end
            end else begin
              ld_col <= ld_col + 1'b1;
            end
          end
        end
        default: begin
          if (!SHARED_MAC) begin
            vec_ready <= 1'b1;
            if (vec_acc) begin
              el_idx <= (el_idx == LAST) ? '0 : el_idx + 1'b1;
              done   <= (el_idx == LAST);
            end
          end else if (vec_acc) begin
            vec_ready <= 1'b0;
            busy      <= 1'b1;
            col       <= '0;
          end else if (busy) begin
            if (col == LAST) begin
              busy      <= 1'b0;
              vec_ready <= 1'b1;
              col       <= '0;
              el_idx    <= (el_idx == LAST) ? '0 : el_idx + 1'b1;
              done      <= (el_idx == LAST);
            end else begin
              col <= col + 1'b1;
            end
          end else begin
            vec_ready <= 1'b1;
          end
        end
      endcase
    end
  end

  // R2: once the run phase starts it is left only through reset
  p_run_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |=> (phase == PH_RUN));

  if (SHARED_MAC) begin : g_area_chk
    // R10: an accepted word blocks the input while the multiplier works on it
    p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
      vec_acc |=> (!vec_ready && busy));
  end else begin : g_pipe_chk
    // R9: the pipelined variant never stalls the input in the run phase
    p_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN && $past(phase == PH_RUN)) |-> vec_ready);
  end
endmodule

// File: rtl/vx_emit.sv
module vx_emit #(
  parameter int DIM   = 4,
  parameter int INT_W = 16,
  parameter int OUT_W = 14,
  localparam int CW   = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int DROP = INT_W - OUT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [DIM-1:0][INT_W-1:0] acc_in,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_data
);
  logic [DIM-1:0][OUT_W-1:0] narrow;
  logic [DIM-2:0][OUT_W-1:0] pend;
  logic [CW-1:0]             left;

  for (genvar c = 0; c < DIM; c++) begin : g_nar
    assign narrow[c] = acc_in[c][INT_W-1 -: OUT_W];
    if (DROP > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^acc_in[c][DROP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      left      <= '0;
    end else if (load) begin
      out_data  <= narrow[0];
      for (int c = 0; c < DIM - 1; c++) pend[c] <= narrow[c+1];
      left      <= CW'(DIM - 1);
      out_valid <= 1'b1;
    end else if (left != '0) begin
      out_data  <= pend[0];
      for (int c = 0; c < DIM - 2; c++) pend[c] <= pend[c+1];
      left      <= left - 1'b1;
      out_valid <= 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R1: no result word appears in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: rtl/vecmat_xform.sv
module vecmat_xform #(
  parameter int IN_W       = 14,
  parameter int INT_W      = 16,
  parameter int OUT_W      = 14,
  parameter int DIM        = 4,
  parameter bit SHARED_MAC = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic                    in_valid,
  output logic                    mat_ready,
  output logic                    vec_ready,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    out_valid
);
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1;

  logic                      coef_wr, first, hold_en, done;
  logic [RW-1:0]             ld_row, ld_col, el_idx;
  logic [DIM-1:0]            col_en;
  logic [DIM-1:0][IN_W-1:0]  row_coef;
  logic [DIM-1:0][INT_W-1:0] prod;
  logic [DIM-1:0][INT_W-1:0] acc;

  vx_seq #(.DIM(DIM), .SHARED_MAC(SHARED_MAC)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .mat_ready(mat_ready), .vec_ready(vec_ready),
    .coef_wr(coef_wr), .ld_row(ld_row), .ld_col(ld_col),
    .el_idx(el_idx), .col_en(col_en), .first(first),
    .hold_en(hold_en), .done(done)
  );

  vx_coef_store #(.IN_W(IN_W), .DIM(DIM)) u_store (
    .clk(clk), .wr_en(coef_wr), .wr_row(ld_row), .wr_col(ld_col),
    .wr_data(in_data), .rd_row(el_idx), .row_q(row_coef)
  );

  if (SHARED_MAC) begin : g_shared
    logic signed [IN_W-1:0]  a_hold;
    logic [IN_W-1:0]         t_sel;
    logic signed [INT_W-1:0] p_one;

    always_ff @(posedge clk) begin
      if (hold_en) a_hold <= in_data;
    end

    always_comb begin
      t_sel = '0;
      for (int c = 0; c < DIM; c++) begin
        if (col_en[c]) t_sel = t_sel | row_coef[c];
      end
    end

    vx_sat_mul #(.IN_W(IN_W), .INT_W(INT_W)) u_mul (
      .a(a_hold), .t(t_sel), .p(p_one)
    );

    for (genvar c = 0; c < DIM; c++) begin : g_fan
      assign prod[c] = p_one;
    end
  end else begin : g_pipe
    for (genvar c = 0; c < DIM; c++) begin : g_mul
      vx_sat_mul #(.IN_W(IN_W), .INT_W(INT_W)) u_mul (
        .a(in_data), .t(row_coef[c]), .p(prod[c])
      );
    end
  end

  for (genvar c = 0; c < DIM; c++) begin : g_col
    vx_acc_col #(.INT_W(INT_W)) u_acc (
      .clk(clk), .rst(rst), .en(col_en[c]), .first(first),
      .p(prod[c]), .acc(acc[c])
    );
  end

  vx_emit #(.DIM(DIM), .INT_W(INT_W), .OUT_W(OUT_W)) u_emit (
    .clk(clk), .rst(rst), .load(done), .acc_in(acc),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R3: coefficient and vector transfers are never offered together
  p_ready_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mat_ready && vec_ready));
endmodule

// File: tb/vecmat_xform_test.sv
`timescale 1ns/1ps
module vecmat_xform_test;
  localparam int IW = 8;
  localparam int NW = 12;
  localparam int OW = 10;
  localparam int D  = 4;
  localparam int NV = 8;

  localparam int MAT1 [16] = '{1, 2, 3, 4, -1, 0, 5, -6,
                               10, -20, 30, -40, 127, -128, 64, -3};
  localparam int MAT2 [16] = '{7, -3, 0, 2, 1, 1, 1, 1,
                               -50, 60, -70, 80, 0, 0, 0, 9};
  localparam int VECS [NV][4] = '{
    '{4, 0, 0, 0}, '{0, 4, 0, 0}, '{0, 0, 4, 0}, '{0, 0, 0, 4},
    '{127, 127, 127, 127}, '{-128, -128, -128, -128},
    '{3, -7, 11, -2}, '{-1, -1, -1, -1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] din [2];
  logic vld [2];
  logic mr [2];
  logic vr [2];
  logic ov [2];
  logic signed [OW-1:0] dout [2];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int mat [16];
  int got [2][64];
  int n_got [2];
  int burst [2];
  int lowrun [2];
  bit seen_run [2];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vecmat_xform #(.IN_W(IW), .INT_W(NW), .OUT_W(OW), .DIM(D), .SHARED_MAC(1'b0)) uut (
    .clk(clk), .rst(rst), .in_data(din[0]), .in_valid(vld[0]),
    .mat_ready(mr[0]), .vec_ready(vr[0]), .out_data(dout[0]), .out_valid(ov[0]));

  vecmat_xform #(.IN_W(IW), .INT_W(NW), .OUT_W(OW), .DIM(D), .SHARED_MAC(1'b1)) uut_area (
    .clk(clk), .rst(rst), .in_data(din[1]), .in_valid(vld[1]),
    .mat_ready(mr[1]), .vec_ready(vr[1]), .out_data(dout[1]), .out_valid(ov[1]));

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clamp(int v);
    int hi = (1 << (NW - 1)) - 1;
    int lo = -(1 << (NW - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // reference from R4 R6 R7 R8
  function automatic int ref_col(int v, int j);
    int acc = 0;
    for (int i = 0; i < 4; i++) begin
      int p = clamp(VECS[v][i] * mat[i*4 + j]);
      acc = (i == 0) ? p : clamp(acc + p);
    end
    return acc >>> (NW - OW);
  endfunction

  function automatic string tag_of(int v);
    if (v < 4) return "R4 unit-vector row pick";
    if (v < 6) return "R6 R7 clamped product and sum";
    return "R8 narrowed result";
  endfunction

  // monitors: sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    for (int l = 0; l < 2; l++) begin
      if (rst) begin
        burst[l] = 0;
        lowrun[l] = 0;
        seen_run[l] = 1'b0;
      end else begin
        if (ov[l]) begin
          if (n_got[l] < 64) got[l][n_got[l]] = dout[l];
          n_got[l]++;
          burst[l]++;
        end else if (burst[l] != 0) begin
          chk("R5 output burst length multiple of 4", burst[l] % 4, 0);
          burst[l] = 0;
        end
        if (mr[l] && vr[l]) chk("R3 both readies high", 1, 0);
        if (seen_run[l] && mr[l]) chk("R2 mat_ready returned after load", 1, 0);
        if (vr[l]) begin
          if (l == 1 && lowrun[l] != 0) chk("R10 vec_ready low span", lowrun[l], 4);
          seen_run[l] = 1'b1;
          lowrun[l] = 0;
        end else if (seen_run[l]) begin
          if (l == 0) chk("R9 vec_ready dropped in run phase", 1, 0);
          lowrun[l]++;
        end
      end
    end
  end

  task automatic send(int l, int val);
    din[l] = val[IW-1:0];
    vld[l] = 1'b1;
    while (!(mr[l] || vr[l])) @(negedge clk);
    @(negedge clk);
    vld[l] = 1'b0;
  endtask

  task automatic load_mat(int l, bit second);
    for (int k = 0; k < 16; k++) send(l, second ? MAT2[k] : MAT1[k]);
  endtask

  task automatic stream(int l, int v0, int v1, int gap);
    for (int v = v0; v <= v1; v++) begin
      for (int i = 0; i < 4; i++) begin
        send(l, VECS[v][i]);
        repeat (gap) @(negedge clk);
      end
    end
  endtask

  task automatic compare(int v0, int v1, string tag);
    for (int l = 0; l < 2; l++) begin
      int k = 0;
      chk({tag, " R5 word count"}, n_got[l], (v1 - v0 + 1) * 4);
      for (int v = v0; v <= v1; v++) begin
        for (int j = 0; j < 4; j++) begin
          chk((tag == "") ? tag_of(v) : tag, got[l][k], ref_col(v, j));
          k++;
        end
      end
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    int t0;
    int t1;
    vld = '{1'b0, 1'b0};
    din = '{'0, '0};
    n_got = '{0, 0};
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      chk("R1 mat_ready in reset", mr[l], 0);
      chk("R1 vec_ready in reset", vr[l], 0);
      chk("R1 out_valid in reset", ov[l], 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      chk("R1 mat_ready after release", mr[l], 1);
      chk("R3 vec_ready during load", vr[l], 0);
    end

    for (int k = 0; k < 16; k++) mat[k] = MAT1[k];
    fork
      load_mat(0, 1'b0);
      load_mat(1, 1'b0);
    join
    for (int l = 0; l < 2; l++) chk("R2 mat_ready low after 16 words", mr[l], 0);
    @(negedge clk);

    fork
      begin
        t0 = cyc;
        stream(0, 0, NV - 1, 0);
        t1 = cyc;
      end
      stream(1, 0, NV - 1, 0);
    join
    chk("R9 cycles for 32 back-to-back words", t1 - t0, 32);
    repeat (40) @(negedge clk);
    compare(0, NV - 1, "");

    n_got = '{0, 0};
    fork
      stream(0, 4, 7, 3);
      stream(1, 4, 7, 2);
    join
    repeat (40) @(negedge clk);
    compare(4, 7, "R11 idle gaps");

    fork
      begin send(0, VECS[6][0]); send(0, VECS[6][1]); end
      begin send(1, VECS[6][0]); send(1, VECS[6][1]); end
    join
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      chk("R1 R12 mat_ready in mid-vector reset", mr[l], 0);
      chk("R1 R12 vec_ready in mid-vector reset", vr[l], 0);
    end
    n_got = '{0, 0};
    rst = 1'b0;
    @(negedge clk);
    for (int l = 0; l < 2; l++) chk("R12 mat_ready after second reset", mr[l], 1);
    for (int k = 0; k < 16; k++) mat[k] = MAT2[k];
    fork
      load_mat(0, 1'b1);
      load_mat(1, 1'b1);
    join
    fork
      stream(0, 0, NV - 1, 0);
      stream(1, 0, NV - 1, 1);
    join
    repeat (40) @(negedge clk);
    compare(0, NV - 1, "R12 reloaded matrix");

    report();
  end
endmodule